// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability Register Block

This block holds the configuration-space registers of a PCI message-signalled interrupt capability. It also turns per-vector interrupt requests from the device into memory-write message requests, each with a 64-bit address and a 32-bit data word. Configuration software writes the block through a port that carries a byte offset, a width code and a data word. A separate combinational port reads it back. Three parameters fix the capability: whether a 64-bit address is supported, whether per-vector masking is supported, and how many vectors the device can request.

Each interrupt request input sets a pending bit. The pending bit is set only when the function is enabled and the vector index is below the enabled vector count. A vector is eligible when it is pending and not masked. The eligible vector with the lowest index is presented on the message port. Its pending bit clears when the consumer accepts the message with the ready input. The register layout moves with the capability parameters: the data word, the upper address word and the mask word sit at offsets that depend on whether 64-bit addressing is supported.

Top module: `msi_msg_cap`

## Requirements
- R1: The control word reads back in the upper half of the dword at offset 0x0 (lower half reads 0). Its layout is: bit 0 enable, bits 3:1 vectors-capable code, bits 6:4 vectors-enabled code, bit 7 64-bit capable, bit 8 per-vector-mask capable, bits 15:9 zero. Writes change only bit 0 and bits 6:4; all other bits keep the parameter values. After reset, the writable bits are 0.
- R2: A 2-byte write (width code 2) at offset 0x2 loads control from data bits 15:0. A 4-byte write (width code 4) at offset 0x0 loads control from data bits 31:16.
- R3: A 4-byte write at 0x4 loads the low address word with bits 1:0 forced to 0. A message address never has bits 1:0 set.
- R4: With 64-bit support, the upper address word is at 0x8, message data at 0xC and the mask word at 0x10. Without it, data is at 0x8 and mask at 0xC. Data is written by a 2- or 4-byte access and keeps data bits 15:0. Reads of data return it zero-extended.
- R5: The mask word exists only with per-vector masking. Without it, writes to that offset are rejected and the offset reads 0. With it, the pending word reads at the mask offset plus 4.
- R6: The enabled vector count is 2 to the power of the vectors-enabled code. Codes 6 and 7 give zero vectors. Requests on vectors at or above the count are ignored.
- R7: A message for vector n carries the address {upper word, low word}, with the upper half 0 without 64-bit support, and data {16'h0, message data OR n}.
- R8: With masking supported, a requested vector whose mask bit is set becomes pending but sends nothing. Clearing the mask bit then sends it. Among eligible vectors, the lowest index is sent first.
- R9: While the enable bit is 0, no message is presented and requests are dropped without becoming pending.
- R10: The length output is 0xA, plus 0x4 with 64-bit support, plus 0xA with masking support.
- R11: A write with a width code other than 2 or 4, or to an offset not valid for that width, changes no register and sets a sticky error flag that only reset clears.
- R12: An accepted message clears that vector's pending bit. If a new request for the same vector arrives in the accepting cycle, the bit stays set and the vector is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrOff | input | OFF_W | Write byte offset within the capability |
| cfgWrBytes | input | 3 | Write width code (2 or 4 valid) |
| cfgWrData | input | 32 | Write data |
| cfgRdOff | input | OFF_W | Dword-aligned read offset |
| cfgRdData | output | 32 | Read data (combinational) |
| irqReq | input | 32 | Per-vector interrupt request pulses |
| msgReady | input | 1 | Consumer accepts the presented message |
| msgValid | output | 1 | A message is presented |
| msgAddr | output | 64 | Message address |
| msgData | output | 32 | Message data |
| capLen | output | 8 | Capability length in bytes |
| errFlag | output | 1 | Sticky rejected-write flag |

## Verification
A request and an acceptance of the same vector can fall in the same clock edge. The pending bit then has to be both cleared and set. The bench provokes this by raising the request for the presented vector in the cycle where ready is high. It then judges that the message is still presented with the same data and disappears only after a second acceptance. A write that sets or clears a mask bit can also meet a pending vector. The bench checks that the message appears in the cycle after the unmasking write.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  localparam int MAX_VEC = 32;
  localparam int VEC_W   = $clog2(MAX_VEC);

  // write strobes passed from the decoder to the datapath
  typedef struct packed {
    logic        ctl;
    logic        addrLo;
    logic        addrHi;
    logic        data;
    logic        mask;
    logic        err;
    logic [15:0] ctlVal;
  } msiWrStrobe_t;

  // vectors allowed by a vectors-enabled code: 2**code, none above 5
  function automatic logic [MAX_VEC-1:0] vecLimit(input logic [2:0] code);
    logic [MAX_VEC-1:0] m;
    for (int i = 0; i < MAX_VEC; i++)
      m[i] = (code <= 3'd5) && (i < (1 << code));
    return m;
  endfunction

endpackage

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl
  import msi_cap_pkg::*;
#(
  parameter bit CAP_64  = 1'b1,
  parameter bit CAP_PVM = 1'b1,
  parameter int OFF_W   = 8
) (
  input  logic             wrEn,
  input  logic [OFF_W-1:0] wrOff,
  input  logic [2:0]       wrBytes,
  input  logic [31:0]      wrData,
  output msiWrStrobe_t     strb
);

  localparam logic [OFF_W-1:0] CTL_HALF_OFF = OFF_W'(8'h02);
  localparam logic [OFF_W-1:0] CTL_WORD_OFF = OFF_W'(8'h00);
  localparam logic [OFF_W-1:0] LO_OFF       = OFF_W'(8'h04);
  localparam logic [OFF_W-1:0] HI_OFF       = OFF_W'(8'h08);
  localparam logic [OFF_W-1:0] DATA_OFF     = CAP_64 ? OFF_W'(8'h0C) : OFF_W'(8'h08);
  localparam logic [OFF_W-1:0] MASK_OFF     = CAP_64 ? OFF_W'(8'h10) : OFF_W'(8'h0C);

  always_comb begin
    strb = '0;
    if (wrEn) begin
      if (wrBytes == 3'd2) begin
        if (wrOff == CTL_HALF_OFF) begin
          strb.ctl    = 1'b1;
          strb.ctlVal = wrData[15:0];
        end else if (wrOff == DATA_OFF) begin
          strb.data = 1'b1;
        end else begin
          strb.err = 1'b1;
        end
      end else if (wrBytes == 3'd4) begin
        if (wrOff == CTL_WORD_OFF) begin
          strb.ctl    = 1'b1;
          strb.ctlVal = wrData[31:16];
        end else if (wrOff == LO_OFF) begin
          strb.addrLo = 1'b1;
        end else if (wrOff == DATA_OFF) begin
          strb.data = 1'b1;
        end else if (CAP_64 && wrOff == HI_OFF) begin
          strb.addrHi = 1'b1;
        end else if (CAP_PVM && wrOff == MASK_OFF) begin
          strb.mask = 1'b1;
        end else begin
          strb.err = 1'b1;
        end
      end else begin
        strb.err = 1'b1;
      end
    end
  end

endmodule

// File: rtl/msi_cap_dpath.sv
module msi_cap_dpath
  import msi_cap_pkg::*;
#(
  parameter bit       CAP_64  = 1'b1,
  parameter bit       CAP_PVM = 1'b1,
  parameter bit [2:0] CAP_MMC = 3'd5,
  parameter int       OFF_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  msiWrStrobe_t       strb,
  input  logic [31:0]        wrData,
  input  logic [OFF_W-1:0]   rdOff,
  output logic [31:0]        rdData,
  input  logic [MAX_VEC-1:0] irqReq,
  input  logic               msgReady,
  output logic               msgValid,
  output logic [63:0]        msgAddr,
  output logic [31:0]        msgData,
  output logic [VEC_W-1:0]   msgVec,
  output logic               errFlag,
  output logic [15:0]        ctlOut,
  output logic [MAX_VEC-1:0] maskOut,
  output logic [MAX_VEC-1:0] pendOut
);

  localparam logic [15:0] CTL_WMASK = 16'h0071;
  localparam logic [15:0] CTL_RO    = {7'b0, CAP_PVM, CAP_64, 3'b000, CAP_MMC, 1'b0};
  localparam logic [OFF_W-1:0] LO_OFF   = OFF_W'(8'h04);
  localparam logic [OFF_W-1:0] HI_OFF   = OFF_W'(8'h08);
  localparam logic [OFF_W-1:0] DATA_OFF = CAP_64 ? OFF_W'(8'h0C) : OFF_W'(8'h08);
  localparam logic [OFF_W-1:0] MASK_OFF = CAP_64 ? OFF_W'(8'h10) : OFF_W'(8'h0C);
  localparam logic [OFF_W-1:0] PEND_OFF = MASK_OFF + OFF_W'(4);

  logic [15:0]        ctlRw;
  logic [31:0]        addrLo;
  logic [31:0]        addrHi;
  logic [15:0]        dataReg;
  logic [MAX_VEC-1:0] pendQ;
  logic [MAX_VEC-1:0] effMask;
  logic [MAX_VEC-1:0] limitMask;
  logic [MAX_VEC-1:0] eligible;
  logic [MAX_VEC-1:0] grantMask;
  logic [MAX_VEC-1:0] reqTake;
  logic [15:0]        ctl;
  logic               enable;

  assign ctl       = (ctlRw & CTL_WMASK) | CTL_RO;
  assign enable    = ctl[0];
  assign limitMask = vecLimit(ctl[6:4]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctlRw   <= '0;
      addrLo  <= '0;
      addrHi  <= '0;
      dataReg <= '0;
      errFlag <= 1'b0;
    end else begin
      if (strb.ctl)    ctlRw   <= strb.ctlVal & CTL_WMASK;
      if (strb.addrLo) addrLo  <= {wrData[31:2], 2'b00};
      if (strb.addrHi) addrHi  <= wrData;
      if (strb.data)   dataReg <= wrData[15:0];
      if (strb.err)    errFlag <= 1'b1;
    end
  end

  // per-vector mask storage only when the capability offers it
  generate
    if (CAP_PVM) begin : g_mask
      logic [MAX_VEC-1:0] maskQ;
      always_ff @(posedge clk) begin
        if (!rst_n)         maskQ <= '0;
        else if (strb.mask) maskQ <= wrData;
      end
      assign effMask = maskQ;
    end else begin : g_nomask
      assign effMask = '0;
    end
  endgenerate

  // lowest-index eligible vector wins
  assign eligible = pendQ & ~effMask & limitMask & {MAX_VEC{enable}};

  always_comb begin
    msgVec = '0;
    for (int i = MAX_VEC - 1; i >= 0; i--)
      if (eligible[i]) msgVec = VEC_W'(i);
  end

  assign msgValid  = |eligible;
  assign grantMask = (msgValid && msgReady) ? (MAX_VEC'(1) << msgVec) : '0;
  assign reqTake   = irqReq & limitMask & {MAX_VEC{enable}};

  always_ff @(posedge clk) begin
    if (!rst_n) pendQ <= '0;
    else        pendQ <= (pendQ & ~grantMask) | reqTake;
  end

  assign msgAddr = {(CAP_64 ? addrHi : 32'h0), addrLo};
  assign msgData = {16'h0, dataReg | {{(16-VEC_W){1'b0}}, msgVec}};

  always_comb begin
    if (rdOff == OFF_W'(0))                 rdData = {ctl, 16'h0};
    else if (rdOff == LO_OFF)               rdData = addrLo;
    else if (rdOff == DATA_OFF)             rdData = {16'h0, dataReg};
    else if (CAP_64 && rdOff == HI_OFF)     rdData = addrHi;
    else if (CAP_PVM && rdOff == MASK_OFF)  rdData = effMask;
    else if (CAP_PVM && rdOff == PEND_OFF)  rdData = pendQ;
    else                                    rdData = '0;
  end

  assign ctlOut  = ctl;
  assign maskOut = effMask;
  assign pendOut = pendQ;

endmodule

// File: rtl/msi_msg_cap.sv
module msi_msg_cap
  import msi_cap_pkg::*;
#(
  parameter bit       CAP_64  = 1'b1,
  parameter bit       CAP_PVM = 1'b1,
  parameter bit [2:0] CAP_MMC = 3'd5,
  parameter int       OFF_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgWrEn,
  input  logic [OFF_W-1:0]   cfgWrOff,
  input  logic [2:0]         cfgWrBytes,
  input  logic [31:0]        cfgWrData,
  input  logic [OFF_W-1:0]   cfgRdOff,
  output logic [31:0]        cfgRdData,
  input  logic [MAX_VEC-1:0] irqReq,
  input  logic               msgReady,
  output logic               msgValid,
  output logic [63:0]        msgAddr,
  output logic [31:0]        msgData,
  output logic [7:0]         capLen,
  output logic               errFlag
);

  localparam logic [7:0] LEN = 8'h0A + (CAP_64 ? 8'h04 : 8'h00) + (CAP_PVM ? 8'h0A : 8'h00);

  msiWrStrobe_t       wrStrb;
  logic [VEC_W-1:0]   curVec;
  logic [15:0]        ctlWord;
  logic [MAX_VEC-1:0] maskWord;
  logic [MAX_VEC-1:0] pendWord;

  assign capLen = LEN;

  msi_cap_ctrl #(.CAP_64(CAP_64), .CAP_PVM(CAP_PVM), .OFF_W(OFF_W)) ctrl_i (
    .wrEn    (cfgWrEn),
    .wrOff   (cfgWrOff),
    .wrBytes (cfgWrBytes),
    .wrData  (cfgWrData),
    .strb    (wrStrb)
  );

  msi_cap_dpath #(.CAP_64(CAP_64), .CAP_PVM(CAP_PVM), .CAP_MMC(CAP_MMC), .OFF_W(OFF_W)) dpath_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (wrStrb),
    .wrData   (cfgWrData),
    .rdOff    (cfgRdOff),
    .rdData   (cfgRdData),
    .irqReq   (irqReq),
    .msgReady (msgReady),
    .msgValid (msgValid),
    .msgAddr  (msgAddr),
    .msgData  (msgData),
    .msgVec   (curVec),
    .errFlag  (errFlag),
    .ctlOut   (ctlWord),
    .maskOut  (maskWord),
    .pendOut  (pendWord)
  );

endmodule

// File: rtl/msi_msg_cap_chk.sv
module msi_msg_cap_chk
  import msi_cap_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               msgValid,
  input logic               msgReady,
  input logic [63:0]        msgAddr,
  input logic [VEC_W-1:0]   msgVec,
  input logic [MAX_VEC-1:0] irqReq,
  input logic               errFlag,
  input logic [15:0]        ctl,
  input logic [MAX_VEC-1:0] mask,
  input logic [MAX_VEC-1:0] pend
);

  // R9
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msgValid |-> ctl[0]);

  // R3
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msgValid |-> (msgAddr[1:0] == 2'b00));

  // R8
  masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msgValid |-> !mask[msgVec]);

  // R12
  sent_is_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msgValid |-> pend[msgVec]);

  // R12
  accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msgValid && msgReady && !irqReq[msgVec]) |=> !pend[$past(msgVec)]);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag |=> errFlag);

endmodule

bind msi_msg_cap msi_msg_cap_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .msgValid (msgValid),
  .msgReady (msgReady),
  .msgAddr  (msgAddr),
  .msgVec   (curVec),
  .irqReq   (irqReq),
  .errFlag  (errFlag),
  .ctl      (ctlWord),
  .mask     (maskWord),
  .pend     (pendWord)
);

// File: tb/msi_msg_cap_tb_top.sv
`timescale 1ns/1ps
module msi_msg_cap_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  // instance A: 64-bit, masking, up to 32 vectors
  logic        aWrEn = 0; logic [7:0] aWrOff = 0; logic [2:0] aWrBytes = 0; logic [31:0] aWrData = 0;
  logic [7:0]  aRdOff = 0; logic [31:0] aRdData;
  logic [31:0] aIrq = 0; logic aRdy = 0; logic aValid; logic [63:0] aAddr; logic [31:0] aData;
  logic [7:0]  aLen; logic aErr;

  // instance B: 32-bit, no masking, up to 4 vectors
  logic        bWrEn = 0; logic [7:0] bWrOff = 0; logic [2:0] bWrBytes = 0; logic [31:0] bWrData = 0;
  logic [7:0]  bRdOff = 0; logic [31:0] bRdData;
  logic [31:0] bIrq = 0; logic bRdy = 0; logic bValid; logic [63:0] bAddr; logic [31:0] bData;
  logic [7:0]  bLen; logic bErr;

  msi_msg_cap #(.CAP_64(1'b1), .CAP_PVM(1'b1), .CAP_MMC(3'd5)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(aWrEn), .cfgWrOff(aWrOff), .cfgWrBytes(aWrBytes),
    .cfgWrData(aWrData), .cfgRdOff(aRdOff), .cfgRdData(aRdData), .irqReq(aIrq),
    .msgReady(aRdy), .msgValid(aValid), .msgAddr(aAddr), .msgData(aData),
    .capLen(aLen), .errFlag(aErr));

  msi_msg_cap #(.CAP_64(1'b0), .CAP_PVM(1'b0), .CAP_MMC(3'd2)) dutB_i (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(bWrEn), .cfgWrOff(bWrOff), .cfgWrBytes(bWrBytes),
    .cfgWrData(bWrData), .cfgRdOff(bRdOff), .cfgRdData(bRdData), .irqReq(bIrq),
    .msgReady(bRdy), .msgValid(bValid), .msgAddr(bAddr), .msgData(bData),
    .capLen(bLen), .errFlag(bErr));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrA(input logic [7:0] off, input logic [2:0] nb, input logic [31:0] d);
    @(negedge clk); aWrEn = 1; aWrOff = off; aWrBytes = nb; aWrData = d;
    @(negedge clk); aWrEn = 0; #1;
  endtask

  task automatic wrB(input logic [7:0] off, input logic [2:0] nb, input logic [31:0] d);
    @(negedge clk); bWrEn = 1; bWrOff = off; bWrBytes = nb; bWrData = d;
    @(negedge clk); bWrEn = 0; #1;
  endtask

  task automatic pulseA(input logic [31:0] v);
    @(negedge clk); aIrq = v;
    @(negedge clk); aIrq = 0; #1;
  endtask

  task automatic acceptA();
    @(negedge clk); aRdy = 1;
    @(negedge clk); aRdy = 0; #1;
  endtask

  function automatic logic [31:0] rdA(input logic [7:0] off);
    aRdOff = off;
    return 32'h0;
  endfunction

  task automatic readA(input logic [7:0] off, output logic [31:0] v);
    aRdOff = off; #1; v = aRdData;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    nRun++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] r;
    logic [31:0] dummy;
    dummy = rdA(8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;

    // reset state
    readA(8'h00, r); chk("R1 reset ctl A", r, 32'h018A_0000);
    chk("R9 reset no message", aValid, 0);
    chk("R11 reset err", aErr, 0);
    chk("R10 length A", aLen, 8'h18);
    chk("R10 length B", bLen, 8'h0A);
    bRdOff = 8'h00; #1; chk("R1 reset ctl B", bRdData, 32'h0004_0000);

    // control write restrictions, both access forms
    wrA(8'h00, 3'd4, 32'hFFFF_0000);
    readA(8'h00, r); chk("R2 dword ctl write", r, 32'h01FB_0000);
    wrA(8'h02, 3'd2, 32'h0000_0000);
    readA(8'h00, r); chk("R1 ctl clear keeps caps", r, 32'h018A_0000);
    wrA(8'h02, 3'd2, 32'h0000_FFFF);
    readA(8'h00, r); chk("R2 half ctl write", r, 32'h01FB_0000);
    wrA(8'h00, 3'd4, 32'h0000_FFFF);
    readA(8'h00, r); chk("R2 dword low half ignored", r, 32'h018A_0000);

    // address and data layout
    wrA(8'h04, 3'd4, 32'h1234_567F);
    readA(8'h04, r); chk("R3 low addr forced align", r, 32'h1234_567C);
    wrA(8'h08, 3'd4, 32'hCAFE_0001);
    readA(8'h08, r); chk("R4 upper addr at 0x8", r, 32'hCAFE_0001);
    wrA(8'h0C, 3'd4, 32'hFFFF_BEE0);
    readA(8'h0C, r); chk("R4 data at 0xC", r, 32'h0000_BEE0);
    readA(8'h10, r); chk("R5 mask reset", r, 32'h0);
    chk("R11 no error on valid writes", aErr, 0);

    // sweep of enabled-vector code against every vector
    for (int m = 0; m < 8; m++) begin
      wrA(8'h02, 3'd2, 32'h0001 | (m << 4));
      for (int v = 0; v < 32; v++) begin
        logic expV;
        expV = (m <= 5) && (v < (1 << m));
        pulseA(32'h1 << v);
        chk("R6 vector acceptance", aValid, expV);
        if (expV) begin
          chk("R7 data merge", aData, 32'h0000_BEE0 | v);
          chk("R7 address", aAddr, 64'hCAFE_0001_1234_567C);
          acceptA();
          chk("R12 accept clears", aValid, 0);
        end
      end
    end
    wrA(8'h02, 3'd2, 32'h0051);

    // masking and pending
    wrA(8'h10, 3'd4, 32'h0000_0008);
    pulseA(32'h0000_0008);
    chk("R8 masked silent", aValid, 0);
    readA(8'h14, r); chk("R8 masked pends", r, 32'h0000_0008);
    wrA(8'h10, 3'd4, 32'h0);
    chk("R8 unmask sends", aValid, 1);
    chk("R8 unmask data", aData, 32'h0000_BEE3);
    acceptA();

    // lowest index first
    pulseA(32'h0000_0024);
    chk("R8 lowest first", aData, 32'h0000_BEE2);
    acceptA();
    chk("R8 next vector", aData, 32'h0000_BEE5);
    chk("R8 next valid", aValid, 1);
    acceptA();
    chk("R8 drained", aValid, 0);

    // same-cycle request and accept
    pulseA(32'h0000_0080);
    @(negedge clk); aRdy = 1; aIrq = 32'h0000_0080;
    @(negedge clk); aRdy = 0; aIrq = 0; #1;
    chk("R12 collision keeps pending", aValid, 1);
    chk("R12 collision data", aData, 32'h0000_BEE7);
    acceptA();
    chk("R12 collision drained", aValid, 0);

    // disabled: requests dropped
    wrA(8'h02, 3'd2, 32'h0050);
    pulseA(32'h0000_0002);
    chk("R9 disabled silent", aValid, 0);
    wrA(8'h02, 3'd2, 32'h0051);
    chk("R9 disabled request dropped", aValid, 0);

    // rejected writes
    wrA(8'h04, 3'd2, 32'hFFFF_FFFF);
    chk("R11 bad offset flags", aErr, 1);
    readA(8'h04, r); chk("R11 bad offset no change", r, 32'h1234_567C);
    wrA(8'h00, 3'd1, 32'h0000_0000);
    readA(8'h00, r); chk("R11 bad width no change", r, 32'h01DB_0000);
    wrA(8'h04, 3'd4, 32'h1234_5678);
    chk("R11 flag sticky", aErr, 1);

    // instance B: 32-bit layout, no masking
    wrB(8'h08, 3'd4, 32'h0000_ABC0);
    bRdOff = 8'h08; #1; chk("R4 data at 0x8 no 64", bRdData, 32'h0000_ABC0);
    wrB(8'h04, 3'd4, 32'h0000_1002);
    chk("R11 B clean", bErr, 0);
    wrB(8'h0C, 3'd4, 32'hFFFF_FFFF);
    chk("R5 mask write rejected", bErr, 1);
    bRdOff = 8'h0C; #1; chk("R5 mask reads zero", bRdData, 32'h0);
    wrB(8'h02, 3'd2, 32'h0021);
    @(negedge clk); bIrq = 32'h0000_0018;
    @(negedge clk); bIrq = 0; #1;
    chk("R5 no masking B", bValid, 1);
    chk("R7 data B", bData, 32'h0000_ABC3);
    chk("R7 addr upper zero", bAddr, 64'h0000_0000_0000_1000);
    @(negedge clk); bRdy = 1;
    @(negedge clk); bRdy = 0; #1;
    chk("R6 vector 4 ignored B", bValid, 0);

    finishRun();
  end

endmodule